// File: doc/BRIEF.md
# Striped Interrupt Vector Router

The router gathers a wide field of interrupt vectors, each raised by a single-cycle pulse from the host-link interrupt logic, and keeps one pending bit per vector. A software-programmed enable word masks each pending bit. The bits that survive are folded onto four interrupt groups. A two-bit routing mode chooses how vectors map to groups: contiguous quarters, a two-way interleave inside each half, or a four-way interleave on the low address bits. A bank-select bit sends the four groups to output lines 4 to 7 instead of 0 to 3.

Software reaches the block through a plain word-addressed register port. The port covers the eight enable words, eight pending words (write one to clear) and one configuration word. Every output line is a registered level. A change to the configuration or to an enable word shows on the lines at the clock edge after the write. Pending state is kept across the change.

Top module: `irq_stripe_router`

## Requirements
- R1: After reset, all enable bits, all pending bits, the routing mode and the bank select read as zero, and all eight output lines are low.
- R2: A one-cycle pulse on `set_vec[v]` sets pending bit v. The bit stays set until it is cleared. Pending bit v reads back at word index 8 + v/32, bit v%32.
- R3: A write to word index 8 + k clears pending bits 32k+b for each bit b written as 1. Bits written as 0 are left unchanged.
- R4: When a set pulse and a clearing write reach the same pending bit in the same cycle, the bit ends up set.
- R5: Each line is a registered OR of (pending AND enable) over the vectors routed to it, taken from the state before the clock edge. Enable bit v sits at word index v/32, bit v%32. With every enabled bit idle, every line is low.
- R6: Mode code 0 (configuration word bits [1:0]) routes vector v to group v[7:6].
- R7: Mode code 1 routes vector v to group {v[7], v[0]}.
- R8: Mode code 2 routes vector v to group v[1:0]. The reserved code 3 routes exactly as code 0.
- R9: With bank select (configuration word bit 2) at 0, group g drives line g and lines 7..4 stay low. With it at 1, group g drives line 4+g and lines 3..0 stay low.
- R10: A write to the configuration word or to an enable word changes the lines at the next clock edge. No pending bit is lost.
- R11: Word index 16 reads {29'b0, bank, mode}. Word indices 0 to 7 read the enable words, and 8 to 15 read the pending words. Any other index reads zero, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vec | input | 256 | Per-vector one-cycle set pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from index) |
| irq_line | output | 8 | Level interrupt lines |

## Verification
Two events can reach the same pending bit in one clock: a set pulse from the link side and a write-one-to-clear from software. The bench drives both at a vector in a single cycle. It then reads the pending word back and checks the bit is still set, and it checks that the vector's line stays asserted. Random stretches mix set pulses with clears, enable writes and mode writes. The bench compares every cycle against a behavioural model that applies the clear before the set.

// File: rtl/irq_stripe_pkg.sv
package irq_stripe_pkg;

   typedef enum logic [1:0] {
      ROUTE_BLOCK = 2'd0,
      ROUTE_PAIR  = 2'd1,
      ROUTE_QUAD  = 2'd2,
      ROUTE_RSVD  = 2'd3
   } route_mode_e;

   typedef struct packed {
      logic        bank_hi;
      route_mode_e mode;
   } route_cfg_t;

   localparam int GROUPS   = 4;
   localparam int CFG_BITS = $bits(route_cfg_t);

endpackage

// File: rtl/irq_stripe_regs.sv
module irq_stripe_regs
   import irq_stripe_pkg::*;
#(
   parameter int NUM_VEC = 256,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_VEC-1:0] pend_q,
   output logic [NUM_VEC-1:0] en_q,
   output route_cfg_t         cfg_q,
   output logic [NUM_VEC-1:0] clr_mask
);

   localparam int NUM_WORDS = NUM_VEC / DATA_W;
   localparam int PEND_BASE = NUM_WORDS;
   localparam int CFG_IDX   = 2 * NUM_WORDS;

   generate
      if (NUM_VEC % DATA_W != 0)
         $error("NUM_VEC must be a whole number of register words");
      if (DATA_W < CFG_BITS)
         $error("register word too narrow for configuration");
      if ((CFG_IDX + 1) > (1 << ADDR_W))
         $error("ADDR_W too small for the register map");
   endgenerate

   logic cfg_hit;
   assign cfg_hit = reg_we && (reg_addr == ADDR_W'(CFG_IDX));

   genvar w;
   generate
      for (w = 0; w < NUM_WORDS; w++) begin : g_word
         logic en_hit, clr_hit;
         assign en_hit  = reg_we && (reg_addr == ADDR_W'(w));
         assign clr_hit = reg_we && (reg_addr == ADDR_W'(PEND_BASE + w));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               en_q[w*DATA_W +: DATA_W] <= '0;
            else if (en_hit)
               en_q[w*DATA_W +: DATA_W] <= reg_wdata;
         end

         assign clr_mask[w*DATA_W +: DATA_W] = clr_hit ? reg_wdata : '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (cfg_hit)
         cfg_q <= route_cfg_t'(reg_wdata[CFG_BITS-1:0]);
   end

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (reg_addr == ADDR_W'(i))
            reg_rdata = en_q[i*DATA_W +: DATA_W];
         if (reg_addr == ADDR_W'(PEND_BASE + i))
            reg_rdata = pend_q[i*DATA_W +: DATA_W];
      end
      if (reg_addr == ADDR_W'(CFG_IDX))
         reg_rdata = DATA_W'(cfg_q);
   end

   // R10: a configuration write is visible in the next cycle
   p_cfg_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hit |=> (cfg_q == route_cfg_t'($past(reg_wdata[CFG_BITS-1:0]))));

endmodule

// File: rtl/irq_stripe_pending.sv
module irq_stripe_pending #(
   parameter int NUM_VEC = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_vec,
   input  logic [NUM_VEC-1:0] clr_mask,
   output logic [NUM_VEC-1:0] pend_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~clr_mask) | set_vec;
   end

   // R2: uncleared pending bits are retained
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_q & $past(pend_q & ~clr_mask)) == $past(pend_q & ~clr_mask)));

   // R4: a set pulse always lands, even against a clear
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

   // R3: cleared bits with no concurrent set drop
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_mask & ~set_vec) != '0) |=> ((pend_q & $past(clr_mask & ~set_vec)) == '0));

endmodule

// File: rtl/irq_stripe_fold.sv
module irq_stripe_fold
   import irq_stripe_pkg::*;
#(
   parameter int NUM_VEC = 256
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_VEC-1:0]  hit,
   input  route_cfg_t          cfg,
   output logic [2*GROUPS-1:0] irq_q
);

   localparam int VW = $clog2(NUM_VEC);

   generate
      if (NUM_VEC < 8 || (NUM_VEC & (NUM_VEC - 1)) != 0)
         $error("NUM_VEC must be a power of two of at least 8");
   endgenerate

   function automatic logic [NUM_VEC-1:0] grp_mask(input route_mode_e m, input int g);
      logic [NUM_VEC-1:0] mk;
      logic [VW-1:0]      vb;
      logic [1:0]         li;
      mk = '0;
      for (int v = 0; v < NUM_VEC; v++) begin
         vb = VW'(v);
         case (m)
            ROUTE_PAIR: li = {vb[VW-1], vb[0]};
            ROUTE_QUAD: li = vb[1:0];
            default:    li = vb[VW-1:VW-2];
         endcase
         mk[v] = (li == 2'(g));
      end
      return mk;
   endfunction

   logic [GROUPS-1:0] grp_hit;

   genvar g;
   generate
      for (g = 0; g < GROUPS; g++) begin : g_grp
         localparam logic [NUM_VEC-1:0] M_BLOCK = grp_mask(ROUTE_BLOCK, g);
         localparam logic [NUM_VEC-1:0] M_PAIR  = grp_mask(ROUTE_PAIR, g);
         localparam logic [NUM_VEC-1:0] M_QUAD  = grp_mask(ROUTE_QUAD, g);
         always_comb begin
            case (cfg.mode)
               ROUTE_PAIR: grp_hit[g] = |(hit & M_PAIR);
               ROUTE_QUAD: grp_hit[g] = |(hit & M_QUAD);
               default:    grp_hit[g] = |(hit & M_BLOCK);
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= '0;
      else if (cfg.bank_hi)
         irq_q <= {grp_hit, {GROUPS{1'b0}}};
      else
         irq_q <= {{GROUPS{1'b0}}, grp_hit};
   end

   // R5: nothing enabled and pending means quiet lines
   p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |=> (irq_q == '0));

   // R9: the unselected bank stays low
   p_low_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.bank_hi |=> (irq_q[2*GROUPS-1:GROUPS] == '0));
   p_high_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg.bank_hi |=> (irq_q[GROUPS-1:0] == '0));

   // R5: any live vector raises some line
   p_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> (irq_q != '0));

endmodule

// File: rtl/irq_stripe_router.sv
module irq_stripe_router
   import irq_stripe_pkg::*;
#(
   parameter int NUM_VEC = 256,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] set_vec,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [2*GROUPS-1:0] irq_line
);

   logic [NUM_VEC-1:0] pend_q;
   logic [NUM_VEC-1:0] en_q;
   logic [NUM_VEC-1:0] clr_mask;
   logic [NUM_VEC-1:0] hit;
   route_cfg_t         cfg_q;

   irq_stripe_regs #(
      .NUM_VEC (NUM_VEC),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pend_q    (pend_q),
      .en_q      (en_q),
      .cfg_q     (cfg_q),
      .clr_mask  (clr_mask)
   );

   irq_stripe_pending #(
      .NUM_VEC (NUM_VEC)
   ) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_vec  (set_vec),
      .clr_mask (clr_mask),
      .pend_q   (pend_q)
   );

   assign hit = pend_q & en_q;

   irq_stripe_fold #(
      .NUM_VEC (NUM_VEC)
   ) u_fold (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit),
      .cfg   (cfg_q),
      .irq_q (irq_line)
   );

   // R10: an enable change leaves pending state untouched
   p_keep_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: tb/irq_stripe_router_test.sv
`timescale 1ns/100ps
module irq_stripe_router_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] set_vec = '0;
   logic         reg_we = 1'b0;
   logic [4:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [7:0]   irq_line;

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";

   // model state
   bit [255:0] m_pend;
   bit [255:0] m_en;
   int         m_mode;
   bit         m_hi;
   bit [7:0]   m_exp;

   always #2.5 clk = ~clk;

   irq_stripe_router uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_line  (irq_line)
   );

   function automatic bit [7:0] model_lines();
      bit [7:0] r = '0;
      int l;
      for (int v = 0; v < 256; v++) begin
         if (m_pend[v] && m_en[v]) begin
            if (m_mode == 1)      l = ((v / 128) * 2) + (v % 2);
            else if (m_mode == 2) l = v % 4;
            else                  l = v / 64;
            r[l + (m_hi ? 4 : 0)] = 1'b1;
         end
      end
      return r;
   endfunction

   function automatic bit [31:0] model_read(int a);
      if (a < 8)        return m_en[a*32 +: 32];
      else if (a < 16)  return m_pend[(a-8)*32 +: 32];
      else if (a == 16) return {29'b0, m_hi, 2'(m_mode)};
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = '0; m_en = '0; m_mode = 0; m_hi = 0; m_exp = '0;
      end else begin
         m_exp = model_lines();
         if (reg_we) begin
            if (reg_addr < 8)
               m_en[reg_addr*32 +: 32] = reg_wdata;
            else if (reg_addr < 16)
               m_pend[(reg_addr-8)*32 +: 32] = m_pend[(reg_addr-8)*32 +: 32] & ~reg_wdata;
            else if (reg_addr == 16) begin
               m_mode = int'(reg_wdata[1:0]);
               m_hi   = reg_wdata[2];
            end
         end
         m_pend = m_pend | set_vec;
      end
   end

   // per-cycle line comparison (R5..R9 depending on phase)
   always @(negedge clk) begin
      n_chk++;
      if (irq_line !== m_exp) begin
         n_bad++;
         $display("FAIL %s irq_line got %h exp %h", cur_req, irq_line, m_exp);
      end
   end

   task automatic cyc(input bit we, input int a, input bit [31:0] d, input bit [255:0] s);
      @(negedge clk);
      reg_we    = we;
      reg_addr  = 5'(a);
      reg_wdata = d;
      set_vec   = s;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, '0);
   endtask

   task automatic wr(input int a, input bit [31:0] d);
      cyc(1, a, d, '0);
   endtask

   task automatic pulse(input int v);
      bit [255:0] s = '0;
      s[v] = 1'b1;
      cyc(0, 0, 0, s);
   endtask

   task automatic chk_rd(input int a, input string tag);
      bit [31:0] e;
      cyc(0, a, 0, '0);
      #1;
      e = model_read(a);
      n_chk++;
      if (reg_rdata !== e) begin
         n_bad++;
         $display("FAIL %s read idx %0d got %h exp %h", tag, a, reg_rdata, e);
      end
   endtask

   task automatic clear_all();
      for (int k = 8; k < 16; k++) wr(k, 32'hFFFF_FFFF);
   endtask

   task automatic walk(input string tag);
      int vs[10] = '{0, 1, 2, 3, 63, 64, 127, 128, 191, 255};
      cur_req = tag;
      foreach (vs[i]) begin
         pulse(vs[i]);
         idle(2);
         clear_all();
         idle(1);
      end
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      bit [255:0] s;
      idle(3);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      cur_req = "R1";
      for (int a = 0; a < 17; a++) chk_rd(a, "R1");
      idle(2);

      // R5 masked vectors stay quiet; R2 pending readback
      cur_req = "R5";
      pulse(5); pulse(100);
      idle(2);
      chk_rd(8, "R2");
      chk_rd(11, "R2");

      // R10 enabling releases held pending state next edge
      cur_req = "R10";
      for (int k = 0; k < 8; k++) wr(k, 32'hFFFF_FFFF);
      idle(3);
      chk_rd(0, "R10");
      clear_all();
      idle(1);

      walk("R6");
      wr(16, 32'h1); idle(1);
      chk_rd(16, "R11");
      walk("R7");
      wr(16, 32'h2); idle(1);
      walk("R8");
      wr(16, 32'h3); idle(1);
      walk("R8");
      wr(16, 32'h6); idle(1);
      chk_rd(16, "R11");
      walk("R9");
      wr(16, 32'h4); idle(1);
      walk("R9");

      // R3 partial clear
      cur_req = "R3";
      wr(16, 32'h0);
      s = '0; s[31:0] = 32'hF0F0_00FF;
      cyc(0, 0, 0, s);
      wr(8, 32'h0000_000F);
      chk_rd(8, "R3");
      idle(1);

      // R4 set and clear in the same cycle
      cur_req = "R4";
      clear_all();
      s = '0; s[200] = 1'b1;
      cyc(1, 14, 32'h0000_0100, s);
      idle(1);
      chk_rd(14, "R4");
      idle(2);

      // R10 mode and enable changes keep pending
      cur_req = "R10";
      wr(6, 32'h0); idle(2);
      chk_rd(14, "R10");
      wr(16, 32'h2); idle(1);
      wr(6, 32'hFFFF_FFFF); idle(2);

      // R11 unmapped reads and writes
      cur_req = "R11";
      wr(17, 32'hFFFF_FFFF);
      wr(31, 32'hFFFF_FFFF);
      chk_rd(17, "R11");
      chk_rd(31, "R11");
      chk_rd(16, "R11");

      // mixed random traffic
      cur_req = "R5";
      for (int i = 0; i < 400; i++) begin
         bit [255:0] rs = '0;
         int a;
         for (int j = 0; j < 3; j++) rs[$urandom_range(255, 0)] = ($urandom_range(3, 0) == 0);
         a = $urandom_range(17, 0);
         cyc($urandom_range(1, 0) == 1, a,
             (a == 16) ? 32'($urandom_range(7, 0)) : 32'($urandom), rs);
         if (i % 50 == 0) chk_rd($urandom_range(16, 0), "R5");
      end
      idle(3);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule